// File: doc/BRIEF.md
# Wake-up and watchdog reset supervisor

This block keeps a sleeping microcontroller on a regular schedule and pulls it out of a hang. It drives a periodic wake-up square wave on `wake_out`. Each rising edge of that wave tells the controller to service the watchdog line `wdog_in` with a falling edge. The first such edge in a cycle ends the high phase of the wave at once. If a whole cycle passes without one, the block drives its active-low reset output `rst_n_out` at the end of that cycle.

The reset output is also asserted whenever the supply-good flag `supply_ok` is low, including at power-up. The block treats that flag as synchronous to `clk`. After reset releases, a short idle gap passes before the wave starts again. Every duration is a whole number of base units, and `UNIT_CYC` sets the length of one base unit in clock cycles. The watchdog line may be asynchronous. It passes through a synchronizer before its falling edges are detected.

Top module: `wake_supervisor`

## Requirements
- R1: When serviced, the wake-up wave repeats with a period of `WAKE_HI_UNITS + WAKE_LO_UNITS` units. It is high for the first `WAKE_HI_UNITS` units of each cycle and low for the rest. With defaults this is 16 clocks high and 16 clocks low.
- R2: The first falling edge on `wdog_in` in a cycle drives `wake_out` low on the third rising clock edge after the input changes. That is two synchronizer flops plus one state update. `wake_out` then stays low until the next cycle starts.
- R3: Further falling edges of `wdog_in` in a cycle that is already serviced change nothing. The next cycle still starts on schedule.
- R4: If no falling edge of `wdog_in` reaches the control logic during a cycle, `rst_n_out` goes low on the clock edge that ends that cycle.
- R5: With `supply_ok` high, a reset lasts `RST_UNITS` units. With defaults this is 40 clocks.
- R6: `wake_out` is low in every cycle in which `rst_n_out` is low.
- R7: After `rst_n_out` rises, `wake_out` stays low for `IDLE_UNITS` units (16 clocks with defaults). It then rises to start a new cycle.
- R8: `supply_ok` low drives `rst_n_out` low on the next clock edge and holds it low. `rst_n_out` rises `RST_UNITS` units after `supply_ok` returns high.
- R9: Falling edges of `wdog_in` that occur while reset is asserted or during the idle gap are discarded. They do not service the following cycle.
- R10: A falling edge that reaches the control logic in the last clock of a cycle still counts as service for that cycle.
- R11: While `arst_n` is low, `wake_out` and `rst_n_out` are both low. All counters restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low power-on reset |
| wdog_in | input | 1 | Watchdog service line from the controller; asynchronous |
| supply_ok | input | 1 | Supply in regulation, synchronous to `clk` |
| wake_out | output | 1 | Wake-up square wave |
| rst_n_out | output | 1 | Active-low reset to the controller |

## Verification
The bench builds the block with `UNIT_CYC = 8` and the default unit counts. A cycle is then 32 clocks and a reset 40 clocks, so fewer than 450 clocks cover many cases:
- normal service
- a repeated edge within one serviced cycle
- a missed cycle
- stray edges during reset and during the idle gap
- service arriving in the final clock of a cycle
- a supply dropout with recovery

These short spans let every expected edge be placed on an exact clock number. A slip of even one clock is therefore reported.

// File: rtl/wsup_pkg.sv
package wsup_pkg;
  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_IDLE  = 2'd1,
    ST_CYCLE = 2'd2
  } wsup_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/wsup_edge.sv
// Synchronizes the watchdog line and flags each falling edge for one clock.
module wsup_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) sync_q[g] <= 1'b0;
      else if (g == 0) sync_q[g] <= din;
      else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) last_q <= 1'b0;
    else last_q <= sync_q[STAGES-1];
  end

  assign fall = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/wsup_ctrl.sv
// Phase sequencer: reset hold, idle gap, wake-up cycles.
module wsup_ctrl
  import wsup_pkg::*;
#(
  parameter int RST_CYC  = 40,
  parameter int IDLE_CYC = 16,
  parameter int PER_CYC  = 32,
  parameter int CNT_W    = 6
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             supply_ok,
  input  logic             wdog_fall,
  output wsup_state_e      state,
  output logic [CNT_W-1:0] count,
  output logic             served
);
  localparam logic [CNT_W-1:0] RST_LAST  = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_CYC - 1);
  localparam logic [CNT_W-1:0] PER_LAST  = CNT_W'(PER_CYC - 1);

  wsup_state_e      state_d;
  logic [CNT_W-1:0] count_d;
  logic             served_d;

  always_comb begin
    state_d  = state;
    count_d  = count;
    served_d = served;
    unique case (state)
      ST_RESET: begin
        served_d = 1'b0;
        if (!supply_ok) begin
          count_d = '0;
        end else if (count == RST_LAST) begin
          state_d = ST_IDLE;
          count_d = '0;
        end else begin
          count_d = count + 1'b1;
        end
      end
      ST_IDLE: begin
        served_d = 1'b0;
        if (!supply_ok) begin
          state_d = ST_RESET;
          count_d = '0;
        end else if (count == IDLE_LAST) begin
          state_d = ST_CYCLE;
          count_d = '0;
        end else begin
          count_d = count + 1'b1;
        end
      end
      ST_CYCLE: begin
        if (!supply_ok) begin
          state_d  = ST_RESET;
          count_d  = '0;
          served_d = 1'b0;
        end else if (count == PER_LAST) begin
          count_d  = '0;
          served_d = 1'b0;
          if (!(served || wdog_fall)) state_d = ST_RESET;
        end else begin
          count_d = count + 1'b1;
          if (wdog_fall) served_d = 1'b1;
        end
      end
      default: begin
        state_d  = ST_RESET;
        count_d  = '0;
        served_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state  <= ST_RESET;
      count  <= '0;
      served <= 1'b0;
    end else begin
      state  <= state_d;
      count  <= count_d;
      served <= served_d;
    end
  end
endmodule

// File: rtl/wsup_outmap.sv
// Decodes the phase state into the two output pins.
module wsup_outmap
  import wsup_pkg::*;
#(
  parameter int HI_CYC = 16,
  parameter int CNT_W  = 6
) (
  input  wsup_state_e      state,
  input  logic [CNT_W-1:0] count,
  input  logic             served,
  output logic             wake,
  output logic             rst_n
);
  localparam logic [CNT_W-1:0] HI_END = CNT_W'(HI_CYC);

  always_comb begin
    rst_n = (state != ST_RESET);
    wake  = (state == ST_CYCLE) && (count < HI_END) && !served;
  end
endmodule

// File: rtl/wake_supervisor.sv
module wake_supervisor
  import wsup_pkg::*;
#(
  parameter int UNIT_CYC      = 8,
  parameter int WAKE_HI_UNITS = 2,
  parameter int WAKE_LO_UNITS = 2,
  parameter int RST_UNITS     = 5,
  parameter int IDLE_UNITS    = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic wdog_in,
  input  logic supply_ok,
  output logic wake_out,
  output logic rst_n_out
);
  localparam int HI_CYC   = WAKE_HI_UNITS * UNIT_CYC;
  localparam int PER_CYC  = (WAKE_HI_UNITS + WAKE_LO_UNITS) * UNIT_CYC;
  localparam int RST_CYC  = RST_UNITS * UNIT_CYC;
  localparam int IDLE_CYC = IDLE_UNITS * UNIT_CYC;
  localparam int CNT_W    = $clog2(max3(PER_CYC, RST_CYC, IDLE_CYC)) + 1;

  logic             wdog_fall;
  wsup_state_e      state;
  logic [CNT_W-1:0] count;
  logic             served;

  wsup_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .arst_n(arst_n),
    .din   (wdog_in),
    .fall  (wdog_fall)
  );

  wsup_ctrl #(
    .RST_CYC (RST_CYC),
    .IDLE_CYC(IDLE_CYC),
    .PER_CYC (PER_CYC),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .arst_n   (arst_n),
    .supply_ok(supply_ok),
    .wdog_fall(wdog_fall),
    .state    (state),
    .count    (count),
    .served   (served)
  );

  wsup_outmap #(.HI_CYC(HI_CYC), .CNT_W(CNT_W)) u_out (
    .state (state),
    .count (count),
    .served(served),
    .wake  (wake_out),
    .rst_n (rst_n_out)
  );
endmodule

// File: rtl/wsup_checker.sv
module wsup_checker #(
  parameter int UNIT_CYC      = 8,
  parameter int WAKE_HI_UNITS = 2,
  parameter int RST_UNITS     = 5,
  parameter int IDLE_UNITS    = 2
) (
  input logic clk,
  input logic arst_n,
  input logic supply_ok,
  input logic wake,
  input logic rst_n,
  input logic wdog_fall
);
  localparam logic [15:0] HI_LIM   = 16'(WAKE_HI_UNITS * UNIT_CYC);
  localparam logic [15:0] RST_LIM  = 16'(RST_UNITS * UNIT_CYC);
  localparam logic [15:0] IDLE_LIM = 16'(IDLE_UNITS * UNIT_CYC);

  logic [15:0] low_run, high_run, wake_run;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      low_run  <= '0;
      high_run <= '0;
      wake_run <= '0;
    end else begin
      if (rst_n || !supply_ok) low_run <= '0;
      else if (low_run != 16'hFFFF) low_run <= low_run + 1'b1;
      if (!rst_n) high_run <= '0;
      else if (high_run != 16'hFFFF) high_run <= high_run + 1'b1;
      if (!wake) wake_run <= '0;
      else if (wake_run != 16'hFFFF) wake_run <= wake_run + 1'b1;
    end
  end

  assert_wake_high_span_R1: assert property (@(posedge clk) disable iff (!arst_n)
    wake |-> wake_run < HI_LIM);
  assert_service_drops_wake_R2: assert property (@(posedge clk) disable iff (!arst_n)
    (wdog_fall && wake) |=> !wake);
  assert_reset_width_R5: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n) |-> low_run >= RST_LIM);
  assert_wake_low_in_reset_R6: assert property (@(posedge clk) disable iff (!arst_n)
    !rst_n |-> !wake);
  assert_idle_gap_R7: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(wake) |-> high_run >= IDLE_LIM);
  assert_supply_drop_resets_R8: assert property (@(posedge clk) disable iff (!arst_n)
    !supply_ok |=> !rst_n);
  assert_release_needs_supply_R8: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n) |-> $past(supply_ok));
endmodule

bind wake_supervisor wsup_checker #(
  .UNIT_CYC     (UNIT_CYC),
  .WAKE_HI_UNITS(WAKE_HI_UNITS),
  .RST_UNITS    (RST_UNITS),
  .IDLE_UNITS   (IDLE_UNITS)
) u_wsup_checker (
  .clk      (clk),
  .arst_n   (arst_n),
  .supply_ok(supply_ok),
  .wake     (wake_out),
  .rst_n    (rst_n_out),
  .wdog_fall(wdog_fall)
);

// File: tb/test_wake_supervisor.sv
module test_wake_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int UNIT       = 8;
  localparam int WATCHDOG   = 5000;

  localparam int EV_WAKE_RISE = 0;
  localparam int EV_WAKE_FALL = 1;
  localparam int EV_RST_RISE  = 2;
  localparam int EV_RST_FALL  = 3;

  typedef struct {
    int    kind;
    int    at;
    string tag;
  } ev_t;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic wdog_in = 1'b1;
  logic supply_ok = 1'b1;
  logic wake_out, rst_n_out;

  int   cyc;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;
  ev_t  expq[$];
  logic prev_wake = 1'b0;
  logic prev_rst = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_supervisor #(.UNIT_CYC(UNIT)) i_wake_supervisor (
    .clk      (clk),
    .arst_n   (arst_n),
    .wdog_in  (wdog_in),
    .supply_ok(supply_ok),
    .wake_out (wake_out),
    .rst_n_out(rst_n_out)
  );

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) cyc <= 0;
    else cyc <= cyc + 1;
  end

  task automatic expect_ev(input int kind, input int at, input string tag);
    ev_t e;
    e.kind = kind;
    e.at   = at;
    e.tag  = tag;
    expq.push_back(e);
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic seen(input int kind);
    ev_t e;
    checks++;
    if (expq.size() == 0) begin
      fails++;
      $display("FAIL unexpected event: actual kind %0d at %0d expected none", kind, cyc);
    end else begin
      e = expq.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        fails++;
        $display("FAIL %s: actual kind %0d at %0d expected kind %0d at %0d",
                 e.tag, kind, cyc, e.kind, e.at);
      end
    end
  endtask

  // Monitor: turns output edges into events and compares them with the queue.
  always @(negedge clk) begin
    if (arst_n && !done) begin
      if (wake_out !== prev_wake) seen(wake_out ? EV_WAKE_RISE : EV_WAKE_FALL);
      if (rst_n_out !== prev_rst) seen(rst_n_out ? EV_RST_RISE : EV_RST_FALL);
      prev_wake <= wake_out;
      prev_rst  <= rst_n_out;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      report();
      $finish;
    end
  end

  initial begin
    // Schedule of expected output edges (clock numbers since arst release).
    expect_ev(EV_RST_RISE,  40,  "R5 first release");
    expect_ev(EV_WAKE_RISE, 56,  "R7 gap after release");
    expect_ev(EV_WAKE_FALL, 63,  "R2 service cuts wake");
    expect_ev(EV_WAKE_RISE, 88,  "R3 extra edge ignored, next cycle on time");
    expect_ev(EV_WAKE_FALL, 104, "R1 natural high phase");
    expect_ev(EV_RST_FALL,  120, "R4 missed cycle");
    expect_ev(EV_RST_RISE,  160, "R5 reset width");
    expect_ev(EV_WAKE_RISE, 176, "R7 idle gap");
    expect_ev(EV_WAKE_FALL, 192, "R1 high phase");
    expect_ev(EV_RST_FALL,  208, "R9 edges in reset/idle not counted");
    expect_ev(EV_RST_RISE,  248, "R5 reset width");
    expect_ev(EV_WAKE_RISE, 264, "R7 idle gap");
    expect_ev(EV_WAKE_FALL, 280, "R1 high phase");
    expect_ev(EV_WAKE_RISE, 296, "R1 period with late service");
    expect_ev(EV_WAKE_FALL, 312, "R1 high phase");
    expect_ev(EV_WAKE_RISE, 328, "R10 service in last clock");
    expect_ev(EV_WAKE_FALL, 337, "R6 wake drops with reset");
    expect_ev(EV_RST_FALL,  337, "R8 supply drop");
    expect_ev(EV_RST_RISE,  390, "R8 release after supply returns");
    expect_ev(EV_WAKE_RISE, 406, "R7 idle gap");
    expect_ev(EV_WAKE_FALL, 413, "R2 service cuts wake");
    expect_ev(EV_WAKE_RISE, 438, "R1 period");

    repeat (2) @(negedge clk);
    check_bit("R11 wake in reset", wake_out, 1'b0);
    check_bit("R11 rst_n in reset", rst_n_out, 1'b0);
    @(negedge clk);
    arst_n = 1'b1;

    wait_to(60);  wdog_in = 1'b0;   // first service
    wait_to(66);  wdog_in = 1'b1;
    wait_to(70);  wdog_in = 1'b0;   // second edge, same cycle
    wait_to(75);  check_bit("R3 wake stays low", wake_out, 1'b0);
    wait_to(80);  wdog_in = 1'b1;   // no edge in cycle 88..120
    wait_to(130); wdog_in = 1'b0;   // during reset
    wait_to(140); wdog_in = 1'b1;
    wait_to(165); wdog_in = 1'b0;   // during idle gap
    wait_to(170); wdog_in = 1'b1;
    wait_to(290); wdog_in = 1'b0;   // service in low phase
    wait_to(300); wdog_in = 1'b1;
    wait_to(325); wdog_in = 1'b0;   // reaches control in last clock
    wait_to(330); wdog_in = 1'b1;
    wait_to(336); supply_ok = 1'b0;
    wait_to(345);
    check_bit("R8 reset held while supply low", rst_n_out, 1'b0);
    check_bit("R6 wake low during reset", wake_out, 1'b0);
    wait_to(350); supply_ok = 1'b1;
    wait_to(389); check_bit("R8 still in reset", rst_n_out, 1'b0);
    wait_to(410); wdog_in = 1'b0;
    wait_to(420); wdog_in = 1'b1;
    wait_to(450);

    done = 1'b1;
    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL missing events: actual %0d left expected 0, next %s",
               expq.size(), expq[0].tag);
    end
    report();
    $finish;
  end
endmodule